// File: doc/BRIEF.md
# UART Bus Collision Guard

This block sits beside a half-duplex UART transmitter on a shared single-wire or open-drain bus. While a frame is being shifted out, it compares the level the transmitter drives with the level it reads back from the line. The comparison is made only at a chosen sampling instant: either the rising-edge pulse of the transfer clock or an external timer underflow pulse. If the two levels differ, a sticky collision interrupt request is raised. The transmitter's enable bit can optionally be cleared in the same cycle, which stops the sender from fighting the bus.

The block can also gate the start of each frame. When that mode is on, a pending transmission waits until a falling edge is seen on the receive line. The start permit then stays granted until the frame completes, and is re-armed for the next frame. Software controls the block through two byte-wide registers:

- a mode register (address 0), with three live bits:
  - bit 4: sampling source
  - bit 5: automatic disable on collision
  - bit 6: edge-gated start
- a control register (address 1), with:
  - bit 0: transmit enable
  - bit 1: collision request

When the surrounding serial unit runs in clock-synchronous mode, all three mode bits are ignored. They stay stored and readable.

Top module: `uart_coll_guard`

## Requirements
- R1: After reset, the mode register reads 0x00 and transmit enable is 0. The collision request is 0 and the start permit is 0.
- R2: Only mode register bits 4, 5 and 6 are stored. Bits 0 to 3 and bit 7 always read 0, whatever value was written. Reads are combinational on the current address.
- R3: The receive level passes through a two-flop synchronizer, with a reset value of 1. A change on the receive pin can take part in a comparison only from the third clock edge after it is applied.
- R4: A collision occurs when four conditions hold in the same cycle: the selected sample pulse is high, transmit enable is 1, the busy input is 1, and the synchronized receive level differs from the transmit level. With enable or busy low, no collision is ever flagged.
- R5: Mode bit 4 = 0 samples on the transfer-clock pulse. Mode bit 4 = 1 samples on the timer underflow pulse. The pulse that is not selected has no effect.
- R6: The collision request (control bit 1) stays set until a control-register write with bit 1 = 0. Writing 1 never sets it. A collision in the same cycle as a clearing write leaves it set.
- R7: With mode bit 5 = 1, a collision forces transmit enable to 0 on the same edge that sets the request, overriding a software write in that cycle. With bit 5 = 0, enable is untouched by collisions.
- R8: With mode bit 6 = 0, the start permit equals transmit enable.
- R9: With mode bit 6 = 1, the start permit is granted one edge after the synchronized receive level falls from 1 to 0 while enabled. It stays granted until a frame-done pulse or the loss of enable. A frame-done pulse wins over a falling edge in the same cycle.
- R10: With the synchronous-mode input at 1, mode bits 4 to 6 act as 0 but remain stored and readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sync_mode_i | input | 1 | 1 when the serial unit is in clock-synchronous mode |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | 0 = mode register, 1 = control register |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the addressed register |
| txd_i | input | 1 | Level the transmitter is driving |
| rxd_i | input | 1 | Asynchronous level read back from the bus |
| xfer_clk_i | input | 1 | One-cycle pulse at each transfer-clock rising edge |
| tmr_uflow_i | input | 1 | One-cycle timer underflow pulse |
| tx_busy_i | input | 1 | Shifter is sending a frame |
| frame_done_i | input | 1 | One-cycle pulse at the end of a frame |
| tx_en_o | output | 1 | Transmit enable bit |
| tx_start_ok_o | output | 1 | Transmission may start |
| coll_irq_o | output | 1 | Sticky collision interrupt request |

## Verification
The embedded assertions check on every cycle that:
- a request never rises outside an enabled, busy transfer;
- the request holds until a clearing write;
- an automatic disable follows every collision in that mode;
- a granted permit persists until frame end and is only ever granted after an edge;
- synchronous mode never blocks the permit.

Only the bench scenarios can show the rest:
- the three-edge synchronizer latency;
- which pulse source is honoured;
- the write-versus-collision priority;
- reserved-bit masking;
- re-arming after a frame.

The bench shows these by comparing a behavioural model against the ports every cycle.

// File: rtl/ucg_pkg.sv
package ucg_pkg;
  localparam int REG_W      = 8;
  localparam int SYNC_DEPTH = 2;

  // register addresses
  localparam logic ADDR_MODE = 1'b0;
  localparam logic ADDR_CTRL = 1'b1;

  // mode register bit positions
  localparam int BIT_SMP_TMR  = 4;
  localparam int BIT_AUTO_CLR = 5;
  localparam int BIT_EDGE_GO  = 6;

  // control register bit positions
  localparam int BIT_TXEN = 0;
  localparam int BIT_IRQ  = 1;

  typedef struct packed {
    logic edge_go;
    logic auto_clr;
    logic smp_tmr;
  } ucg_mode_t;
endpackage

// File: rtl/ucg_rx_sync.sv
module ucg_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rxd_i,
  output logic rx_lvl_o,
  output logic rx_fall_o
);
  localparam int CHAIN_W = STAGES + 1;

  logic [CHAIN_W-1:0] chain_q;
  logic [CHAIN_W-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[CHAIN_W-2:0], rxd_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;
    else         chain_q <= chain_d;
  end

  assign rx_lvl_o  = chain_q[STAGES-1];
  assign rx_fall_o = chain_q[STAGES] & ~chain_q[STAGES-1];
endmodule

// File: rtl/ucg_regs.sv
module ucg_regs
  import ucg_pkg::*;
#(
  parameter int DW = REG_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          coll_hit_i,
  input  logic          auto_clr_i,
  output ucg_mode_t     mode_o,
  output logic          tx_en_o,
  output logic          irq_o,
  output logic [DW-1:0] rdata_o
);
  ucg_mode_t mode_q, mode_d;
  logic      en_q, en_d;
  logic      irq_q, irq_d;
  logic      wr_mode, wr_ctrl, clr_req;
  logic      wdata_unused;

  assign wdata_unused = ^wdata_i;
  assign wr_mode = we_i && (addr_i == ADDR_MODE);
  assign wr_ctrl = we_i && (addr_i == ADDR_CTRL);
  assign clr_req = wr_ctrl && !wdata_i[BIT_IRQ];

  always_comb begin
    mode_d = mode_q;
    if (wr_mode) begin
      mode_d.smp_tmr  = wdata_i[BIT_SMP_TMR];
      mode_d.auto_clr = wdata_i[BIT_AUTO_CLR];
      mode_d.edge_go  = wdata_i[BIT_EDGE_GO];
    end
    en_d = en_q;
    if (wr_ctrl) en_d = wdata_i[BIT_TXEN];
    if (coll_hit_i && auto_clr_i) en_d = 1'b0;
    irq_d = irq_q;
    if (clr_req) irq_d = 1'b0;
    if (coll_hit_i) irq_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      en_q   <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      en_q   <= en_d;
      irq_q  <= irq_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_MODE) begin
      rdata_o[BIT_SMP_TMR]  = mode_q.smp_tmr;
      rdata_o[BIT_AUTO_CLR] = mode_q.auto_clr;
      rdata_o[BIT_EDGE_GO]  = mode_q.edge_go;
    end else begin
      rdata_o[BIT_TXEN] = en_q;
      rdata_o[BIT_IRQ]  = irq_q;
    end
  end

  assign mode_o  = mode_q;
  assign tx_en_o = en_q;
  assign irq_o   = irq_q;

  // R6
  irq_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !clr_req) |=> irq_q);

  // R7
  auto_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coll_hit_i && auto_clr_i) |=> (!en_q && irq_q));
endmodule

// File: rtl/ucg_start_gate.sv
module ucg_start_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_en_i,
  input  logic edge_mode_i,
  input  logic rx_fall_i,
  input  logic frame_done_i,
  output logic start_ok_o
);
  logic permit_q, permit_d;

  always_comb begin
    permit_d = permit_q;
    if (!tx_en_i || frame_done_i) permit_d = 1'b0;
    else if (rx_fall_i)           permit_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) permit_q <= 1'b0;
    else         permit_q <= permit_d;
  end

  assign start_ok_o = tx_en_i && (edge_mode_i ? permit_q : 1'b1);

  // R9
  permit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (permit_q && tx_en_i && !frame_done_i) |=> permit_q);

  // R9
  grant_after_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(permit_q) |-> $past(rx_fall_i));
endmodule

// File: rtl/uart_coll_guard.sv
module uart_coll_guard
  import ucg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_mode_i,
  input  logic             reg_we_i,
  input  logic             reg_addr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             txd_i,
  input  logic             rxd_i,
  input  logic             xfer_clk_i,
  input  logic             tmr_uflow_i,
  input  logic             tx_busy_i,
  input  logic             frame_done_i,
  output logic             tx_en_o,
  output logic             tx_start_ok_o,
  output logic             coll_irq_o
);
  ucg_mode_t mode_st, mode_eff;
  logic      rx_lvl, rx_fall;
  logic      smp_evt, coll_hit;

  ucg_rx_sync #(.STAGES(SYNC_DEPTH)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rxd_i    (rxd_i),
    .rx_lvl_o (rx_lvl),
    .rx_fall_o(rx_fall)
  );

  // in clock-synchronous mode every special bit behaves as 0
  assign mode_eff = sync_mode_i ? ucg_mode_t'('0) : mode_st;
  assign smp_evt  = mode_eff.smp_tmr ? tmr_uflow_i : xfer_clk_i;
  assign coll_hit = smp_evt && tx_en_o && tx_busy_i && (rx_lvl != txd_i);

  ucg_regs #(.DW(REG_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .coll_hit_i(coll_hit),
    .auto_clr_i(mode_eff.auto_clr),
    .mode_o    (mode_st),
    .tx_en_o   (tx_en_o),
    .irq_o     (coll_irq_o),
    .rdata_o   (reg_rdata_o)
  );

  ucg_start_gate u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tx_en_i     (tx_en_o),
    .edge_mode_i (mode_eff.edge_go),
    .rx_fall_i   (rx_fall),
    .frame_done_i(frame_done_i),
    .start_ok_o  (tx_start_ok_o)
  );

  // R4
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(coll_irq_o) |-> $past(tx_en_o && tx_busy_i));

  // R10
  sync_mode_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_mode_i && tx_en_o) |-> tx_start_ok_o);
endmodule

// File: tb/tb_uart_coll_guard.sv
`timescale 1ns/1ps
module tb_uart_coll_guard;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, sync_mode, we, addr, txd, rxd, xclk, uflow, busy, done;
  logic [7:0] wdata, rdata;
  logic       tx_en, start_ok, irq;

  uart_coll_guard dut (
    .clk_i(clk), .rst_ni(rst_n), .sync_mode_i(sync_mode),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .txd_i(txd), .rxd_i(rxd), .xfer_clk_i(xclk), .tmr_uflow_i(uflow),
    .tx_busy_i(busy), .frame_done_i(done),
    .tx_en_o(tx_en), .tx_start_ok_o(start_ok), .coll_irq_o(irq)
  );

  int n_cmp = 0;
  int n_bad = 0;

  task automatic cmp(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_en, m_irq, m_perm, m_smp, m_auto, m_edge;
  int hist[$];
  int e4, e5, e6, evt, hit, fall, n_en, n_irq, n_perm;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_irq = 0; m_perm = 0; m_smp = 0; m_auto = 0; m_edge = 0;
      hist = '{1, 1, 1};
    end else begin
      e4 = sync_mode ? 0 : m_smp;
      e5 = sync_mode ? 0 : m_auto;
      evt  = e4 ? int'(uflow) : int'(xclk);
      hit  = (evt != 0) && (m_en != 0) && busy && (hist[1] != int'(txd));
      fall = (hist[2] == 1) && (hist[1] == 0);
      n_en = m_en; n_irq = m_irq;
      if (we && addr) begin
        n_en = int'(wdata[0]);
        if (!wdata[1]) n_irq = 0;
      end
      if (hit) begin
        n_irq = 1;
        if (e5 != 0) n_en = 0;
      end
      if (m_en == 0 || done) n_perm = 0;
      else if (fall) n_perm = 1;
      else n_perm = m_perm;
      if (we && !addr) begin
        m_smp = int'(wdata[4]); m_auto = int'(wdata[5]); m_edge = int'(wdata[6]);
      end
      m_en = n_en; m_irq = n_irq; m_perm = n_perm;
      hist.push_front(int'(rxd));
      void'(hist.pop_back());
    end
  end

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      e6 = sync_mode ? 0 : m_edge;
      cmp("R7/R1 tx enable", tx_en, m_en);
      cmp("R4/R6 collision request", irq, m_irq);
      cmp("R8/R9 start permit", start_ok, (m_en != 0) && ((e6 != 0) ? (m_perm != 0) : 1'b1));
      if (!addr) cmp("R2 mode readback", rdata, (m_edge << 6) | (m_auto << 5) | (m_smp << 4));
      else       cmp("R6 control readback", rdata, (m_irq << 1) | m_en);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic a, logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    tick();
    we = 1'b0;
  endtask

  task automatic pulse_x();
    xclk = 1'b1; tick(); xclk = 1'b0;
  endtask

  task automatic pulse_u();
    uflow = 1'b1; tick(); uflow = 1'b0;
  endtask

  task automatic at_neg();
    @(negedge clk);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    rst_n = 1'b0; sync_mode = 1'b0; we = 1'b0; addr = 1'b0; wdata = '0;
    txd = 1'b1; rxd = 1'b1; xclk = 1'b0; uflow = 1'b0; busy = 1'b0; done = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick();
    // R1 reset state
    at_neg();
    cmp("R1 enable after reset", tx_en, 0);
    cmp("R1 request after reset", irq, 0);
    cmp("R1 permit after reset", start_ok, 0);
    cmp("R1 mode after reset", rdata, 8'h00);
    tick();

    // R2 reserved bits
    wr(1'b0, 8'hFF);
    at_neg(); cmp("R2 reserved masked", rdata, 8'h70);
    tick();
    wr(1'b0, 8'h00);

    // R4 idle: mismatch but not enabled / not busy
    rxd = 1'b0; tick(3);
    pulse_x();
    at_neg(); cmp("R4 no flag when disabled", irq, 0);
    tick();
    wr(1'b1, 8'h01);
    pulse_x();
    at_neg(); cmp("R4 no flag when not busy", irq, 0);
    tick();
    busy = 1'b1;
    pulse_x();
    at_neg(); cmp("R4 mismatch flags collision", irq, 1);
    tick();

    // R6 clear, write-one no set, priority
    wr(1'b1, 8'h01);
    at_neg(); cmp("R6 cleared by write 0", irq, 0);
    tick();
    wr(1'b1, 8'h03);
    at_neg(); cmp("R6 write 1 does not set", irq, 0);
    tick();
    xclk = 1'b1; we = 1'b1; addr = 1'b1; wdata = 8'h01;
    tick();
    xclk = 1'b0; we = 1'b0;
    at_neg(); cmp("R6 collision beats clear", irq, 1);
    tick();

    // R3 synchronizer latency
    rxd = 1'b1; tick(3);
    wr(1'b1, 8'h01);
    rxd = 1'b0; xclk = 1'b1;
    tick(2);
    at_neg(); cmp("R3 not yet visible", irq, 0);
    tick();
    xclk = 1'b0;
    at_neg(); cmp("R3 visible on third edge", irq, 1);
    tick();

    // R5 timer source
    wr(1'b1, 8'h01);
    wr(1'b0, 8'h10);
    pulse_x();
    at_neg(); cmp("R5 transfer pulse ignored", irq, 0);
    tick();
    pulse_u();
    at_neg(); cmp("R5 underflow samples", irq, 1);
    tick();

    // R7 automatic disable
    wr(1'b1, 8'h01);
    wr(1'b0, 8'h30);
    uflow = 1'b1; we = 1'b1; addr = 1'b1; wdata = 8'h03;
    tick();
    uflow = 1'b0; we = 1'b0;
    at_neg(); cmp("R7 enable forced low", tx_en, 0);
    cmp("R7 request set", irq, 1);
    tick();
    wr(1'b0, 8'h10);
    wr(1'b1, 8'h01);
    pulse_u();
    at_neg(); cmp("R7 enable kept when off", tx_en, 1);
    tick();

    // R8 / R9 start gating
    rxd = 1'b1; txd = 1'b1; tick(3);
    wr(1'b0, 8'h00);
    wr(1'b1, 8'h01);
    at_neg(); cmp("R8 permit follows enable", start_ok, 1);
    tick();
    wr(1'b0, 8'h40);
    at_neg(); cmp("R9 permit waits for edge", start_ok, 0);
    tick();
    rxd = 1'b0;
    tick(2);
    at_neg(); cmp("R9 not granted before edge seen", start_ok, 0);
    tick();
    at_neg(); cmp("R9 granted after edge", start_ok, 1);
    tick();
    rxd = 1'b1; tick(4);
    at_neg(); cmp("R9 permit held", start_ok, 1);
    tick();
    done = 1'b1; tick(); done = 1'b0;
    at_neg(); cmp("R9 re-armed at frame end", start_ok, 0);
    tick();

    // R10 synchronous mode neutralises mode bits
    wr(1'b0, 8'h70);
    wr(1'b1, 8'h01);
    sync_mode = 1'b1;
    addr = 1'b0;
    at_neg(); cmp("R10 bits still stored", rdata, 8'h70);
    cmp("R10 gate inactive", start_ok, 1);
    tick();
    rxd = 1'b0; tick(3);
    pulse_u();
    at_neg(); cmp("R10 underflow ignored", irq, 0);
    tick();
    pulse_x();
    at_neg(); cmp("R10 transfer pulse used", irq, 1);
    cmp("R10 no auto disable", tx_en, 1);
    tick();
    sync_mode = 1'b0;

    // mixed random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      rxd   = $urandom_range(0, 3) != 0;
      txd   = $urandom_range(0, 3) != 0;
      xclk  = $urandom_range(0, 3) == 0;
      uflow = $urandom_range(0, 3) == 0;
      busy  = $urandom_range(0, 4) != 0;
      done  = $urandom_range(0, 15) == 0;
      sync_mode = $urandom_range(0, 15) == 0;
      we    = $urandom_range(0, 7) == 0;
      addr  = $urandom_range(0, 1) != 0;
      wdata = 8'($urandom);
      if (we && addr && $urandom_range(0, 1) != 0) wdata[0] = 1'b1;
      tick();
    end
    we = 1'b0; xclk = 1'b0; uflow = 1'b0; done = 1'b0;
    tick(2);
    report();
  end
endmodule